// File: doc/BRIEF.md
# Chiplet Control Register Bank

This block is a bank of 64-bit registers for controlling one chiplet. It sits behind a simple register-access port that carries a 10-bit register index, a write flag, an access size in bytes and 64 bits of write data. Only full 8-byte accesses are accepted. The bank holds these words:

- six control words;
- two configuration words;
- a status word, a mask word, a protect-mode word and a lock word.

Each control and configuration word can be written in three ways. A plain write loads the whole word. A set alias ORs the write data into the word. A clear alias removes from the word every bit that is 1 in the write data. The set and clear aliases give atomic bit updates without a read-modify-write sequence.

A read is answered one cycle after the request. The answer carries the read data and at most one of three error pulses. The first pulse marks a read of a write-only alias. The second marks an access to an index that maps to no register. The third marks an access whose size is not 8 bytes. The register contents have no effect on any other logic inside this block.

Top module: `chiplet_ctl_bank`

## Requirements
- R1: After a synchronous active-high reset, every register holds zero. Reading any mapped plain index returns 0, and no error pulse is raised.
- R2: The control words are at indices 0x00 to 0x05 and the configuration words are at 0x08 and 0x09. An 8-byte write to one of these indices replaces the stored word.
- R3: An 8-byte write to index 0x10+n (n = 0..5) ORs the write data into control word n. A write to 0x18 or 0x19 ORs the write data into configuration word 0 or 1.
- R4: An 8-byte write to index 0x20+n (n = 0..5) clears, in control word n, every bit that is 1 in the write data. Writes to 0x28 and 0x29 do the same for configuration words 0 and 1.
- R5: A read of any set or clear alias returns 0xFFFF_FFFF_FFFF_FFFF and pulses rsp_err_wo. The read leaves every register unchanged. A write to an alias raises no error.
- R6: The status word is at 0x100, the mask word at 0x101, the protect-mode word at 0x3FE and the lock word at 0x3FF. Each of them takes a plain write and reads back exactly as stored.
- R7: A read of an index that maps to no register returns all ones and pulses rsp_err_unimp. A write to such an index changes no register and pulses rsp_err_unimp.
- R8: A request whose req_size is not 8 changes no register and pulses rsp_err_size, and no other error pulse is raised with it. If the request is a read, it returns all ones. If it is a write, rsp_rdata keeps its previous value.
- R9: rsp_rdata and the error pulses change in the cycle that follows the request. Each error pulse lasts one cycle. rsp_rdata changes only after a read request. With no request, no error pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_idx | input | 10 | Register index (byte address shifted right by 3) |
| req_size | input | 4 | Access size in bytes; only 8 is accepted |
| req_wdata | input | 64 | Write data |
| rsp_rdata | output | 64 | Read data, registered |
| rsp_err_unimp | output | 1 | Pulse: the request addressed an unmapped index |
| rsp_err_wo | output | 1 | Pulse: a write-only alias was read |
| rsp_err_size | output | 1 | Pulse: the access size was not 8 bytes |

## Verification
A write takes effect at the edge where the request is sampled, so a read issued on the very next cycle already returns the new value. Read data and error pulses appear one edge after the request, and the bench drives each request half a cycle before the edge that takes it. The reference model is updated when the request is driven, and the outputs are compared at the following falling edge, one full register stage later. Idle cycles are compared as well, which checks that rsp_rdata holds its value and that no pulse appears without a request.

// File: rtl/ccb_pkg.sv
package ccb_pkg;

  localparam int WORD_W = 64;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_KEEP = 2'd3
  } ccb_op_e;

  typedef struct packed {
    logic       hit;   // index maps to a register view
    logic       wo;    // view is a write-only alias
    ccb_op_e    op;    // what a write through this view does
    logic [7:0] slot;  // flat storage slot
  } ccb_dec_t;

  // Next value of a word for a write through a view.
  function automatic logic [WORD_W-1:0] word_update(
      input logic [WORD_W-1:0] cur,
      input logic [WORD_W-1:0] data,
      input ccb_op_e           op);
    case (op)
      OP_LOAD: word_update = data;
      OP_SET:  word_update = cur | data;
      OP_CLR:  word_update = cur & ~data;
      default: word_update = cur;
    endcase
  endfunction

endpackage

// File: rtl/ccb_decode.sv
module ccb_decode
  import ccb_pkg::*;
#(
  parameter int AW       = 10,
  parameter int NUM_CTL  = 6,
  parameter int NUM_CFG  = 2,
  parameter int CFG_BASE = 8,
  parameter int SET_OFS  = 'h10,
  parameter int CLR_OFS  = 'h20,
  parameter int IDX_STAT = 'h100,
  parameter int IDX_MASK = 'h101,
  parameter int IDX_PROT = 'h3FE,
  parameter int IDX_LOCK = 'h3FF
) (
  input  logic [AW-1:0] idx,
  output ccb_dec_t      dec
);
  localparam int NUM_ALIASED = NUM_CTL + NUM_CFG;

  always_comb begin
    int iv;
    int rel;
    int ofs;
    iv  = int'(idx);
    dec = '{hit: 1'b0, wo: 1'b0, op: OP_KEEP, slot: 8'd0};
    // Three views (plain, set, clear) of the aliased words.
    for (int k = 0; k < 3; k++) begin
      ofs = (k == 0) ? 0 : ((k == 1) ? SET_OFS : CLR_OFS);
      rel = iv - ofs;
      if (rel >= 0 && rel < NUM_CTL) begin
        dec.hit  = 1'b1;
        dec.slot = 8'(rel);
        dec.wo   = (k != 0);
        dec.op   = (k == 0) ? OP_LOAD : ((k == 1) ? OP_SET : OP_CLR);
      end else if (rel >= CFG_BASE && rel < CFG_BASE + NUM_CFG) begin
        dec.hit  = 1'b1;
        dec.slot = 8'(NUM_CTL + rel - CFG_BASE);
        dec.wo   = (k != 0);
        dec.op   = (k == 0) ? OP_LOAD : ((k == 1) ? OP_SET : OP_CLR);
      end
    end
    // Directly written words.
    if (iv == IDX_STAT) begin
      dec = '{hit: 1'b1, wo: 1'b0, op: OP_LOAD, slot: 8'(NUM_ALIASED)};
    end else if (iv == IDX_MASK) begin
      dec = '{hit: 1'b1, wo: 1'b0, op: OP_LOAD, slot: 8'(NUM_ALIASED + 1)};
    end else if (iv == IDX_PROT) begin
      dec = '{hit: 1'b1, wo: 1'b0, op: OP_LOAD, slot: 8'(NUM_ALIASED + 2)};
    end else if (iv == IDX_LOCK) begin
      dec = '{hit: 1'b1, wo: 1'b0, op: OP_LOAD, slot: 8'(NUM_ALIASED + 3)};
    end
  end

endmodule

// File: rtl/ccb_store.sv
module ccb_store
  import ccb_pkg::*;
#(
  parameter int NW = 12,
  parameter int SW = $clog2(NW)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       we,
  input  logic [SW-1:0]              slot,
  input  ccb_op_e                    op,
  input  logic [WORD_W-1:0]          wdata,
  output logic [NW-1:0][WORD_W-1:0]  words
);
  for (genvar g = 0; g < NW; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst) begin
        words[g] <= '0;
      end else if (we && slot == SW'(g)) begin
        words[g] <= word_update(words[g], wdata, op);
      end
    end
  end

endmodule

// File: rtl/ccb_rsp.sv
module ccb_rsp
  import ccb_pkg::*;
#(
  parameter int NW = 12,
  parameter int SW = $clog2(NW)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic                      req_write,
  input  logic                      size_ok,
  input  logic                      hit,
  input  logic                      wo,
  input  logic [SW-1:0]             slot,
  input  logic [NW-1:0][WORD_W-1:0] words,
  output logic [WORD_W-1:0]         rdata,
  output logic                      err_unimp,
  output logic                      err_wo,
  output logic                      err_size
);
  localparam logic [WORD_W-1:0] ALL_ONES = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= '0;
      err_unimp <= 1'b0;
      err_wo    <= 1'b0;
      err_size  <= 1'b0;
    end else begin
      err_unimp <= 1'b0;
      err_wo    <= 1'b0;
      err_size  <= 1'b0;
      if (req_valid) begin
        if (!size_ok) begin
          err_size <= 1'b1;
          if (!req_write) rdata <= ALL_ONES;
        end else if (!hit) begin
          err_unimp <= 1'b1;
          if (!req_write) rdata <= ALL_ONES;
        end else if (!req_write) begin
          if (wo) begin
            err_wo <= 1'b1;
            rdata  <= ALL_ONES;
          end else begin
            rdata <= words[slot];
          end
        end
      end
    end
  end

endmodule

// File: rtl/chiplet_ctl_bank.sv
module chiplet_ctl_bank
  import ccb_pkg::*;
#(
  parameter int AW        = 10,
  parameter int SZW       = 4,
  parameter int ACC_BYTES = 8,
  parameter int NUM_CTL   = 6,
  parameter int NUM_CFG   = 2,
  parameter int CFG_BASE  = 8,
  parameter int SET_OFS   = 'h10,
  parameter int CLR_OFS   = 'h20,
  parameter int IDX_STAT  = 'h100,
  parameter int IDX_MASK  = 'h101,
  parameter int IDX_PROT  = 'h3FE,
  parameter int IDX_LOCK  = 'h3FF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [AW-1:0]     req_idx,
  input  logic [SZW-1:0]    req_size,
  input  logic [63:0]       req_wdata,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err_unimp,
  output logic              rsp_err_wo,
  output logic              rsp_err_size
);
  localparam int NW = NUM_CTL + NUM_CFG + 4;
  localparam int SW = $clog2(NW);

  ccb_dec_t                  dec;
  logic                      size_ok;
  logic                      wr_fire;
  logic [SW-1:0]             slot;
  logic [NW-1:0][WORD_W-1:0] words;

  assign size_ok = (req_size == SZW'(ACC_BYTES));
  assign wr_fire = req_valid && req_write && size_ok && dec.hit;
  assign slot    = dec.slot[SW-1:0];

  ccb_decode #(
    .AW(AW), .NUM_CTL(NUM_CTL), .NUM_CFG(NUM_CFG), .CFG_BASE(CFG_BASE),
    .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .IDX_STAT(IDX_STAT),
    .IDX_MASK(IDX_MASK), .IDX_PROT(IDX_PROT), .IDX_LOCK(IDX_LOCK)
  ) u_dec (
    .idx (req_idx),
    .dec (dec)
  );

  ccb_store #(.NW(NW), .SW(SW)) u_store (
    .clk   (clk),
    .rst   (rst),
    .we    (wr_fire),
    .slot  (slot),
    .op    (dec.op),
    .wdata (req_wdata),
    .words (words)
  );

  ccb_rsp #(.NW(NW), .SW(SW)) u_rsp (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .size_ok   (size_ok),
    .hit       (dec.hit),
    .wo        (dec.wo),
    .slot      (slot),
    .words     (words),
    .rdata     (rsp_rdata),
    .err_unimp (rsp_err_unimp),
    .err_wo    (rsp_err_wo),
    .err_size  (rsp_err_size)
  );

endmodule

// File: rtl/ccb_chk.sv
module ccb_chk #(
  parameter int SZW       = 4,
  parameter int ACC_BYTES = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           req_valid,
  input logic           req_write,
  input logic [SZW-1:0] req_size,
  input logic [63:0]    rsp_rdata,
  input logic           rsp_err_unimp,
  input logic           rsp_err_wo,
  input logic           rsp_err_size
);
  logic seen;

  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_ERR_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rsp_err_unimp, rsp_err_wo, rsp_err_size})); // R8

  AST_WO_ALL_ONES: assert property (@(posedge clk) disable iff (rst)
    rsp_err_wo |-> (&rsp_rdata)); // R5

  AST_UNIMP_RD_ONES: assert property (@(posedge clk) disable iff (rst || !seen)
    (rsp_err_unimp && !$past(req_write)) |-> (&rsp_rdata)); // R7

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(req_valid) |-> !(rsp_err_unimp || rsp_err_wo || rsp_err_size)); // R9

  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst || !seen)
    !$past(req_valid && !req_write) |-> $stable(rsp_rdata)); // R9

  AST_SIZE_CAUSE: assert property (@(posedge clk) disable iff (rst || !seen)
    rsp_err_size |-> ($past(req_valid) && $past(req_size) != SZW'(ACC_BYTES))); // R8

endmodule

bind chiplet_ctl_bank ccb_chk #(.SZW(SZW), .ACC_BYTES(ACC_BYTES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_write     (req_write),
  .req_size      (req_size),
  .rsp_rdata     (rsp_rdata),
  .rsp_err_unimp (rsp_err_unimp),
  .rsp_err_wo    (rsp_err_wo),
  .rsp_err_size  (rsp_err_size)
);

// File: tb/sim_chiplet_ctl_bank.sv
`timescale 1ns/100ps
module sim_chiplet_ctl_bank;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [9:0]  req_idx = '0;
  logic [3:0]  req_size = 4'd8;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic        rsp_err_unimp, rsp_err_wo, rsp_err_size;

  always #2.5 clk = ~clk;

  chiplet_ctl_bank u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_idx(req_idx), .req_size(req_size), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err_unimp(rsp_err_unimp),
    .rsp_err_wo(rsp_err_wo), .rsp_err_size(rsp_err_size)
  );

  localparam logic [63:0] ONES = '1;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [63:0] shadow [int];
  logic [63:0] exp_rd = '0;
  bit exp_un = 0, exp_wo = 0, exp_sz = 0;
  bit pend = 0;
  string pend_tag = "";

  function automatic bit is_plain(int i);
    return (i inside {[0:5], 8, 9, 256, 257, 1022, 1023});
  endfunction

  // kind: 0 unmapped, 1 plain, 2 set alias, 3 clear alias; home = plain index
  function automatic void classify(int i, output int kind, output int home);
    kind = 0; home = -1;
    if (is_plain(i)) begin kind = 1; home = i; end
    else if (i >= 16 && i < 32 && is_plain(i - 16)) begin kind = 2; home = i - 16; end
    else if (i >= 32 && i < 48 && is_plain(i - 32)) begin kind = 3; home = i - 32; end
  endfunction

  task automatic compare();
    if (!pend) return;
    total++;
    if (rsp_rdata !== exp_rd || rsp_err_unimp !== exp_un ||
        rsp_err_wo !== exp_wo || rsp_err_size !== exp_sz) begin
      bad++;
      $display("FAIL %s: got rd=%h un=%0b wo=%0b sz=%0b exp rd=%h un=%0b wo=%0b sz=%0b",
               pend_tag, rsp_rdata, rsp_err_unimp, rsp_err_wo, rsp_err_size,
               exp_rd, exp_un, exp_wo, exp_sz);
    end
  endtask

  // One clock: compare previous cycle's outputs, drive new request, update model.
  task automatic cyc(bit v, bit w, int idx, int sz, logic [63:0] d, string tag);
    int kind, home;
    @(negedge clk);
    if (done) return;
    compare();
    req_valid = v; req_write = w; req_idx = 10'(idx);
    req_size = 4'(sz); req_wdata = d;
    exp_un = 0; exp_wo = 0; exp_sz = 0;
    if (v) begin
      if (sz != 8) begin
        exp_sz = 1;
        if (!w) exp_rd = ONES;
      end else begin
        classify(idx, kind, home);
        if (kind == 0) begin
          exp_un = 1;
          if (!w) exp_rd = ONES;
        end else if (w) begin
          if (kind == 1) shadow[home] = d;
          else if (kind == 2) shadow[home] = shadow[home] | d;
          else shadow[home] = shadow[home] & ~d;
        end else if (kind != 1) begin
          exp_wo = 1; exp_rd = ONES;
        end else begin
          exp_rd = shadow[home];
        end
      end
    end
    pend = 1; pend_tag = tag;
  endtask

  task automatic wr(int idx, logic [63:0] d, string tag); cyc(1, 1, idx, 8, d, tag); endtask
  task automatic rd(int idx, string tag); cyc(1, 0, idx, 8, '0, tag); endtask
  task automatic idle(string tag); cyc(0, 0, 0, 8, '0, tag); endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    foreach (shadow[k]) shadow.delete(k);
    for (int i = 0; i < 1024; i++) if (is_plain(i)) shadow[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    idle("R1 reset outputs");
    for (int i = 0; i < 1024; i++) if (is_plain(i)) rd(i, "R1 reset value");

    // R2 plain writes replace
    for (int n = 0; n < 6; n++) wr(n, 64'h1111_0000_0000_0000 * (n + 1) + 64'(n), "R2 ctl write");
    wr(8, 64'hDEAD_BEEF_0123_4567, "R2 cfg0 write");
    wr(9, 64'hA5A5_5A5A_F0F0_0F0F, "R2 cfg1 write");
    for (int n = 0; n < 10; n++) rd(n, "R2 readback");
    wr(3, 64'h0000_0000_0000_00FF, "R2 overwrite");
    rd(3, "R2 overwrite readback");

    // R3 set aliases
    wr('h13, 64'hFF00_0000_0000_0000, "R3 set ctl3");
    rd(3, "R3 set ctl3 readback");
    wr('h10, 64'h0000_0000_8000_0001, "R3 set ctl0");
    rd(0, "R3 set ctl0 readback");
    wr('h19, ONES, "R3 set cfg1 all");
    rd(9, "R3 cfg1 all ones");
    wr('h18, 64'h0, "R3 set zero no change");
    rd(8, "R3 cfg0 unchanged");
    wr('h15, 64'h0F, "R3 set ctl5");
    rd(5, "R3 ctl5 readback");

    // R4 clear aliases
    wr('h23, 64'hF000_0000_0000_000F, "R4 clr ctl3");
    rd(3, "R4 clr ctl3 readback");
    wr('h29, 64'h0000_FFFF_0000_FFFF, "R4 clr cfg1");
    rd(9, "R4 cfg1 readback");
    wr('h28, ONES, "R4 clr cfg0 all");
    rd(8, "R4 cfg0 zero");
    wr('h25, 64'h0, "R4 clr zero no change");
    rd(5, "R4 ctl5 unchanged");

    // R5 alias reads
    rd('h11, "R5 read set alias");
    rd('h24, "R5 read clr alias");
    rd('h18, "R5 read cfg set alias");
    rd('h29, "R5 read cfg clr alias");
    for (int n = 0; n < 10; n++) rd(n, "R5 state unchanged");

    // R6 direct words
    wr('h100, 64'h0123_4567_89AB_CDEF, "R6 status write");
    wr('h101, 64'hFEDC_BA98_7654_3210, "R6 mask write");
    wr('h3FE, 64'h8000_0000_0000_0000, "R6 protect write");
    wr('h3FF, 64'h0000_0000_0000_0001, "R6 lock write");
    rd('h100, "R6 status"); rd('h101, "R6 mask");
    rd('h3FE, "R6 protect"); rd('h3FF, "R6 lock");

    // R7 unmapped
    rd('h06, "R7 read 0x06"); rd('h0A, "R7 read 0x0A"); rd('h1F, "R7 read 0x1F");
    rd('h200, "R7 read 0x200"); rd('h3FD, "R7 read 0x3FD"); rd('h110, "R7 read 0x110");
    wr('h07, ONES, "R7 write 0x07"); wr('h2A, ONES, "R7 write 0x2A");
    wr('h102, ONES, "R7 write 0x102");
    for (int n = 0; n < 10; n++) rd(n, "R7 no side effect");
    rd('h100, "R7 status intact");

    // R8 bad size
    cyc(1, 1, 2, 4, ONES, "R8 write size 4");
    rd(2, "R8 ctl2 intact");
    cyc(1, 0, 2, 4, '0, "R8 read size 4");
    cyc(1, 0, 'h101, 0, '0, "R8 read size 0");
    rd(1, "R8 restore rdata");
    cyc(1, 1, 'h3FF, 15, '0, "R8 write size 15 keeps rdata");
    rd('h3FF, "R8 lock intact");
    cyc(1, 0, 'h12, 2, '0, "R8 size err on alias only");
    cyc(1, 1, 'h300, 1, '0, "R8 size err on unmapped only");

    // R9 timing / hold
    rd(4, "R9 read");
    idle("R9 idle hold");
    idle("R9 idle hold 2");
    wr(4, 64'h5555, "R9 write keeps rdata");
    rd(4, "R9 back-to-back read");
    wr('h14, 64'hAAAA, "R9 set then read");
    rd(4, "R9 read after set");
    idle("R9 idle");
    idle("R9 flush");

    @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule